// File: doc/BRIEF.md
# Time-of-Flight Measurement Sequencer

This block is the control core of a start/stop stopwatch. A host sets up a blanking length, the number of STOP events it expects, and how many cycles it wants averaged. It then issues a go request. The sequencer raises a trigger toward an external front end and arms the START input. When a START rising edge arrives, it drops the trigger and runs a coarse reference-clock counter. STOP rising edges are counted only once that counter has reached the programmed blanking value. When the expected number of STOPs has been seen, one cycle is complete.

In averaging mode a finished cycle re-arms the trigger by itself, with no host action, and the interrupt is raised only once the last cycle has ended. If the coarse counter reaches all ones first, the measurement is abandoned: an overflow flag is set and the interrupt is raised anyway. A status-read strobe releases the interrupt. Dropping the enable input puts every setting back to its default. The enable input must also go from low to high once after reset before any go request is honoured.

The states are OFF, READY, ARM, COUNT and DONE. The transitions are:
- any state to OFF when enable is low;
- OFF to READY on an enable rising edge;
- READY to ARM on go;
- ARM to COUNT on a START edge;
- COUNT to ARM on the last STOP of a cycle that is not the final one;
- COUNT to DONE on the last STOP of the final cycle, or on counter overflow;
- DONE to READY on a status read.

Top module: `tof_seq_ctrl`

## Requirements
- R1: After reset the block stays in OFF until enable_i has been seen low and then high. A go_i pulse before that leaves trig_o low.
- R2: A go_i pulse in READY makes trig_o and start_en_o high at the next clock edge.
- R3: A START rising edge seen in ARM makes trig_o and start_en_o low at that edge and sets coarse_o to 0. coarse_o then rises by one at each following edge.
- R4: The blanking value is {high byte at config select 1, low byte at config select 0}. stop_en_o stays low while coarse_o is below it. STOP edges in that window are not counted.
- R5: The expected STOP count sits at config select 2 and is valid from 1 to 5. A write of any other value is dropped. While stop_en_o is high, each STOP rising edge is counted, and the cycle ends at the edge that takes the count to the configured value.
- R6: When the final cycle ends, irq_n_o goes low at that edge while trig_o, start_en_o and stop_en_o go low. irq_n_o stays low until stat_rd_i is pulsed, and it is high again after the edge that samples the pulse.
- R7: The averaging code c (0 to 7) sits at config select 3 and asks for 2^c cycles. The end of each cycle except the last sets trig_o high at that same edge, with irq_n_o held high.
- R8: Once the block is in READY again, a further go_i pulse starts a fresh measurement with the same settings, with no enable toggle needed.
- R9: While enable_i is low, the settings read back their defaults (blanking 0, STOP count 1, averaging code 0), config writes are dropped, and the sequence returns to OFF with trig_o low.
- R10: If coarse_o reaches all ones in COUNT, the next edge sets ovf_o and drives irq_n_o low; with a START edge in the cycle before the edge that clears the counter, that is 65536 cycles after it. ovf_o is cleared by the next go_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also the coarse count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Block enable; low restores defaults |
| go_i | input | 1 | Start-measurement strobe from the host |
| stat_rd_i | input | 1 | Status-read strobe; releases the interrupt |
| start_i | input | 1 | START event from the front end (rising edge) |
| stop_i | input | 1 | STOP event from the front end (rising edge) |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | Config write select: 0 blank low, 1 blank high, 2 STOP count, 3 averaging code |
| cfg_wdata_i | input | 8 | Config write data |
| rd_sel_i | input | 2 | Config readback select, same encoding |
| rd_data_o | output | 8 | Config readback data |
| trig_o | output | 1 | Trigger to the front end |
| start_en_o | output | 1 | START input armed |
| stop_en_o | output | 1 | STOP input open (blanking expired) |
| irq_n_o | output | 1 | Active-low interrupt |
| ovf_o | output | 1 | Coarse counter overflow flag |
| coarse_o | output | 16 | Coarse counter value |

## Verification
The main function is exercised with several blanking lengths. A blanking length of zero checks that STOP is open in the very cycle the counter clears. Short blanking lengths check the boundary where stop_en_o first rises. Stray STOP pulses are placed inside the blanking window, which separates a mask that truly drops edges from one that only delays them. STOP counts from one to five are used with random gaps between pulses, so that an off-by-one in completion shows up as an early or late interrupt. Averaging codes up to 128 cycles show whether the re-trigger happens and whether the interrupt is held back until the final cycle. One run with maximum blanking counts the exact cycle distance to the overflow.

// File: rtl/tof_seq_pkg.sv
`timescale 1ns/1ps
package tof_seq_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_READY,
        S_ARM,
        S_COUNT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        CFG_BLANK_LO = 2'd0,
        CFG_BLANK_HI = 2'd1,
        CFG_STOPS    = 2'd2,
        CFG_AVG      = 2'd3
    } cfg_sel_t;

endpackage

// File: rtl/tof_edge_det.sv
`timescale 1ns/1ps
module tof_edge_det #(
    parameter int          N       = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sig_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise_o[i] = sig_i[i] & ~prev_q[i];
    end

endmodule

// File: rtl/tof_coarse_cnt.sv
`timescale 1ns/1ps
module tof_coarse_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         at_max_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o    = cnt_q;
    assign at_max_o = &cnt_q;

    // R3: counting advances by exactly one per enabled edge
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> (cnt_o == $past(cnt_o) + W'(1)));

endmodule

// File: rtl/tof_cfg_regs.sv
`timescale 1ns/1ps
module tof_cfg_regs
    import tof_seq_pkg::*;
#(
    parameter int MAX_STOPS = 5,
    parameter int STOP_W    = 3,
    parameter int AVG_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              we_i,
    input  logic [1:0]        sel_i,
    input  logic [7:0]        wdata_i,
    input  logic [1:0]        rd_sel_i,
    output logic [15:0]       blank_o,
    output logic [STOP_W-1:0] nstop_o,
    output logic [AVG_W-1:0]  avg_code_o,
    output logic [7:0]        rd_data_o
);

    logic [7:0]        blank_lo_q, blank_hi_q;
    logic [STOP_W-1:0] nstop_q;
    logic [AVG_W-1:0]  avg_q;
    logic              stops_ok;

    assign stops_ok = (wdata_i >= 8'd1) && (wdata_i <= 8'(MAX_STOPS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !enable_i) begin
            blank_lo_q <= '0;
            blank_hi_q <= '0;
            nstop_q    <= STOP_W'(1);
            avg_q      <= '0;
        end else if (we_i) begin
            unique case (sel_i)
                CFG_BLANK_LO: blank_lo_q <= wdata_i;
                CFG_BLANK_HI: blank_hi_q <= wdata_i;
                CFG_STOPS:    if (stops_ok) nstop_q <= wdata_i[STOP_W-1:0];
                CFG_AVG:      avg_q <= wdata_i[AVG_W-1:0];
            endcase
        end
    end

    always_comb begin
        unique case (rd_sel_i)
            CFG_BLANK_LO: rd_data_o = blank_lo_q;
            CFG_BLANK_HI: rd_data_o = blank_hi_q;
            CFG_STOPS:    rd_data_o = 8'(nstop_q);
            CFG_AVG:      rd_data_o = 8'(avg_q);
        endcase
    end

    assign blank_o    = {blank_hi_q, blank_lo_q};
    assign nstop_o    = nstop_q;
    assign avg_code_o = avg_q;

    // R9: a low enable puts every setting back to default
    assert_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (blank_o == 16'd0 && nstop_o == STOP_W'(1) && avg_code_o == '0));

    // R5: the STOP count never leaves its legal range
    assert_stops_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nstop_o != '0) && (nstop_o <= STOP_W'(MAX_STOPS)));

endmodule

// File: rtl/tof_seq_ctrl.sv
`timescale 1ns/1ps
module tof_seq_ctrl
    import tof_seq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int MAX_STOPS = 5,
    parameter int AVG_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             go_i,
    input  logic             stat_rd_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic [7:0]       cfg_wdata_i,
    input  logic [1:0]       rd_sel_i,
    output logic [7:0]       rd_data_o,
    output logic             trig_o,
    output logic             start_en_o,
    output logic             stop_en_o,
    output logic             irq_n_o,
    output logic             ovf_o,
    output logic [CNT_W-1:0] coarse_o
);

    localparam int STOP_W = $clog2(MAX_STOPS + 1);
    localparam int CYC_W  = 1 << AVG_W;

    seq_state_t        state_q, state_d;
    logic [15:0]       blank;
    logic [STOP_W-1:0] nstop, stop_cnt;
    logic [AVG_W-1:0]  avg_code;
    logic [CYC_W-1:0]  cyc_cnt, cyc_last;
    logic [2:0]        rise;
    logic              start_rise, stop_rise, en_rise;
    logic              at_max, stop_open, stop_take, last_stop, last_cycle;
    logic              cnt_clr, cnt_inc, ovf_q;

    tof_cfg_regs #(.MAX_STOPS(MAX_STOPS), .STOP_W(STOP_W), .AVG_W(AVG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
        .rd_sel_i(rd_sel_i), .blank_o(blank), .nstop_o(nstop),
        .avg_code_o(avg_code), .rd_data_o(rd_data_o)
    );

    // enable starts "high" so a level held through reset is not a rising edge
    tof_edge_det #(.N(3), .RST_VAL(3'b100)) u_edges (
        .clk(clk), .rst_n(rst_n),
        .sig_i({enable_i, stop_i, start_i}), .rise_o(rise)
    );
    assign start_rise = rise[0];
    assign stop_rise  = rise[1];
    assign en_rise    = rise[2];

    tof_coarse_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(cnt_clr), .inc_i(cnt_inc),
        .cnt_o(coarse_o), .at_max_o(at_max)
    );

    assign cnt_clr    = (state_q == S_ARM) && start_rise;
    assign cnt_inc    = (state_q == S_COUNT) && !at_max;
    assign stop_open  = coarse_o >= CNT_W'(blank);
    assign stop_take  = (state_q == S_COUNT) && stop_open && stop_rise && !at_max;
    assign last_stop  = stop_cnt == (nstop - STOP_W'(1));
    assign cyc_last   = (CYC_W'(1) << avg_code) - CYC_W'(1);
    assign last_cycle = cyc_cnt == cyc_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable_i) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   if (en_rise)    state_d = S_READY;
                S_READY: if (go_i)       state_d = S_ARM;
                S_ARM:   if (start_rise) state_d = S_COUNT;
                S_COUNT: begin
                    if (at_max)
                        state_d = S_DONE;
                    else if (stop_take && last_stop)
                        state_d = last_cycle ? S_DONE : S_ARM;
                end
                S_DONE:  if (stat_rd_i)  state_d = S_READY;
                default: state_d = S_OFF;
            endcase
        end
    end

    // cycle bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_cnt <= '0;
            cyc_cnt  <= '0;
            ovf_q    <= 1'b0;
        end else if (!enable_i) begin
            stop_cnt <= '0;
            cyc_cnt  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (state_q == S_READY && go_i) begin
                stop_cnt <= '0;
                cyc_cnt  <= '0;
                ovf_q    <= 1'b0;
            end
            if (stop_take) begin
                if (last_stop) begin
                    stop_cnt <= '0;
                    cyc_cnt  <= cyc_cnt + CYC_W'(1);
                end else begin
                    stop_cnt <= stop_cnt + STOP_W'(1);
                end
            end
            if (state_q == S_COUNT && at_max) ovf_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        trig_o     = 1'b0;
        start_en_o = 1'b0;
        stop_en_o  = 1'b0;
        irq_n_o    = 1'b1;
        unique case (state_q)
            S_ARM: begin
                trig_o     = 1'b1;
                start_en_o = 1'b1;
            end
            S_COUNT: stop_en_o = stop_open;
            S_DONE:  irq_n_o   = 1'b0;
            default: ;
        endcase
    end

    assign ovf_o = ovf_q;

    // R3: the START edge drops the trigger and clears the coarse count
    assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ARM && start_rise && enable_i) |=> (!trig_o && coarse_o == '0));

    // R4: a STOP edge inside the blanking window leaves the STOP tally alone
    assert_blank_drops_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_COUNT && !stop_en_o && stop_rise) |=> (stop_cnt == $past(stop_cnt)));

    // R6: the interrupt holds until a status read
    assert_irq_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n_o && !stat_rd_i && enable_i) |=> !irq_n_o);

    // R7: a non-final cycle re-triggers on its own
    assert_retrigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_take && last_stop && !last_cycle && enable_i) |=> (trig_o && irq_n_o));

    // R10: overflow always comes with the interrupt
    assert_ovf_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> !irq_n_o);

endmodule

// File: tb/sim_tof_seq_ctrl.sv
`timescale 1ns/1ps
module sim_tof_seq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n, enable_i, go_i, stat_rd_i, start_i, stop_i, cfg_we_i;
    logic [1:0]  cfg_sel_i, rd_sel_i;
    logic [7:0]  cfg_wdata_i, rd_data_o;
    logic        trig_o, start_en_o, stop_en_o, irq_n_o, ovf_o;
    logic [15:0] coarse_o;

    always #2.5 clk = ~clk;

    tof_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .go_i(go_i),
        .stat_rd_i(stat_rd_i), .start_i(start_i), .stop_i(stop_i),
        .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .trig_o(trig_o),
        .start_en_o(start_en_o), .stop_en_o(stop_en_o), .irq_n_o(irq_n_o),
        .ovf_o(ovf_o), .coarse_o(coarse_o)
    );

    int total = 0;
    int bad   = 0;
    int m_blank, m_nst, m_code;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit stops_ok(int v);
        return (v >= 1) && (v <= 5);
    endfunction

    function automatic int exp_cycles(int code);
        return 1 << code;
    endfunction

    function automatic int exp_rd(int sel);
        case (sel)
            0:       return m_blank & 255;
            1:       return (m_blank >> 8) & 255;
            2:       return m_nst;
            default: return m_code;
        endcase
    endfunction

    task automatic model_defaults();
        m_blank = 0; m_nst = 1; m_code = 0;
    endtask

    task automatic wr(int sel, int val);
        cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_wdata_i = 8'(val);
        if (enable_i) begin
            case (sel)
                0: m_blank = (m_blank & 16'hFF00) | (val & 255);
                1: m_blank = (m_blank & 16'h00FF) | ((val & 255) << 8);
                2: if (stops_ok(val)) m_nst = val;
                default: m_code = val & 7;
            endcase
        end
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic check_rd_all(string req);
        for (int s = 0; s < 4; s++) begin
            rd_sel_i = 2'(s);
            #0.5;
            chk(req, $sformatf("readback sel %0d", s), int'(rd_data_o), exp_rd(s));
        end
    endtask

    task automatic pulse_rd();
        stat_rd_i = 1'b1; @(negedge clk); stat_rd_i = 1'b0;
    endtask

    task automatic run_meas(int blank, int nst, int code, bit early);
        int ncyc, ep;
        wr(0, blank & 255); wr(1, blank >> 8); wr(2, nst); wr(3, code);
        go_i = 1'b1; @(negedge clk); go_i = 1'b0;
        chk("R10", "ovf cleared by go", int'(ovf_o), 0);
        ncyc = exp_cycles(m_code);
        for (int c = 0; c < ncyc; c++) begin
            chk("R2", "trig armed", int'(trig_o), 1);
            chk("R2", "start_en armed", int'(start_en_o), 1);
            repeat ($urandom % 3) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            chk("R3", "trig after START", int'(trig_o), 0);
            chk("R3", "start_en after START", int'(start_en_o), 0);
            chk("R3", "coarse after START", int'(coarse_o), 0);
            ep = (early && m_blank >= 3) ? m_blank / 2 : -1;
            for (int j = 0; j < m_blank; j++) begin
                chk("R3", "coarse step", int'(coarse_o), j);
                chk("R4", "stop_en in blank", int'(stop_en_o), 0);
                stop_i = (j == ep);
                @(negedge clk);
            end
            stop_i = 1'b0;
            chk("R4", "stop_en at blank end", int'(stop_en_o), 1);
            for (int s = 0; s < m_nst; s++) begin
                repeat (1 + $urandom % 3) @(negedge clk);
                stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
                if (s < m_nst - 1) begin
                    chk("R5", "irq before last STOP", int'(irq_n_o), 1);
                    chk("R5", "stop_en before last STOP", int'(stop_en_o), 1);
                end else if (c < ncyc - 1) begin
                    chk("R7", "self re-trigger", int'(trig_o), 1);
                    chk("R7", "irq held mid-average", int'(irq_n_o), 1);
                end else begin
                    chk("R6", "irq at end", int'(irq_n_o), 0);
                    chk("R6", "trig at end", int'(trig_o), 0);
                    chk("R6", "start_en at end", int'(start_en_o), 0);
                    chk("R6", "stop_en at end", int'(stop_en_o), 0);
                    chk("R10", "no ovf on normal end", int'(ovf_o), 0);
                end
            end
        end
        repeat (2) @(negedge clk);
        chk("R6", "irq held before read", int'(irq_n_o), 0);
        pulse_rd();
        chk("R6", "irq released by read", int'(irq_n_o), 1);
    endtask

    initial begin
        int n;
        void'($urandom(32'h7A11));
        rst_n = 1'b0; enable_i = 1'b1; go_i = 1'b0; stat_rd_i = 1'b0;
        start_i = 1'b0; stop_i = 1'b0; cfg_we_i = 1'b0;
        cfg_sel_i = '0; cfg_wdata_i = '0; rd_sel_i = '0;
        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R6", "irq after reset", int'(irq_n_o), 1);
        chk("R1", "trig after reset", int'(trig_o), 0);
        chk("R10", "ovf after reset", int'(ovf_o), 0);
        chk("R3", "coarse after reset", int'(coarse_o), 0);
        check_rd_all("R9");

        // R1: go before an enable rising edge is ignored
        go_i = 1'b1; @(negedge clk); go_i = 1'b0;
        chk("R1", "trig without enable edge", int'(trig_o), 0);
        repeat (3) @(negedge clk);
        chk("R1", "trig still idle", int'(trig_o), 0);
        enable_i = 1'b0; @(negedge clk);
        enable_i = 1'b1; @(negedge clk);

        // R5: illegal STOP counts are dropped
        wr(2, 3); wr(2, 0); wr(2, 6); wr(2, 7);
        check_rd_all("R5");

        // directed corners
        run_meas(0, 1, 0, 1'b0);
        run_meas(5, 5, 2, 1'b1);
        run_meas(1, 2, 0, 1'b0);
        run_meas(0, 1, 7, 1'b0);
        // R8: repeated go with unchanged settings
        for (int k = 0; k < 25; k++)
            run_meas($urandom % 24, 1 + $urandom % 5, $urandom % 4, 1'(($urandom % 2)));

        // R9: disable in mid sequence
        wr(0, 8'h34); wr(1, 8'h12); wr(2, 4); wr(3, 2);
        go_i = 1'b1; @(negedge clk); go_i = 1'b0;
        chk("R2", "trig before disable", int'(trig_o), 1);
        enable_i = 1'b0; @(negedge clk);
        model_defaults();
        chk("R9", "trig after disable", int'(trig_o), 0);
        check_rd_all("R9");
        wr(0, 55); wr(2, 3);
        check_rd_all("R9");
        enable_i = 1'b1; @(negedge clk);
        run_meas(2, 2, 1, 1'b0);

        // R10: coarse overflow
        wr(0, 255); wr(1, 255); wr(2, 1); wr(3, 0);
        go_i = 1'b1; @(negedge clk); go_i = 1'b0;
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        n = 0;
        while (irq_n_o && n < 70000) begin
            @(negedge clk);
            n++;
        end
        chk("R10", "cycles to overflow", n, 65536);
        chk("R10", "ovf set", int'(ovf_o), 1);
        chk("R10", "trig off after overflow", int'(trig_o), 0);
        pulse_rd();
        chk("R6", "irq released after overflow", int'(irq_n_o), 1);
        chk("R10", "ovf held until go", int'(ovf_o), 1);
        run_meas(0, 1, 0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog requirement=all actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule